// File: doc/BRIEF.md
# Host Bus Read Strobe Timer

This block produces 8-bit read cycles on an external host bus that serves two chip selects. A requester presents an address, a chip-select index and a valid flag while the block is idle. The block then runs one access: an address phase of fixed length, a turnaround in multiplexed mode only, and a data phase in which the active-low read strobe stays low for a number of clocks set by a wait-state code. On the clock edge where the strobe returns high it samples the data bus. In the following cycle it returns the byte together with a one-cycle done pulse.

Each chip select has its own sub-mode, wait-state code and one-clock trim bit. These take effect only when a per-select enable input is high. When the enable is low, every select uses the global sub-mode, wait-state code and trim. In sub-mode 0 the address and the data share the 8-bit AD bus, and an address-latch strobe marks the address. In sub-mode 1 the address has its own bus and the AD lines carry only data. Sub-modes 2 and 3 are reserved, and the block refuses any request that would use them. The configuration in effect is captured when a request is accepted and holds for the whole access.

Top module: `hbrd_read_ctrl`

## Requirements
- R1: The address phase lasts exactly ADDR_CYC clocks (default 2) for every wait-state code. In sub-mode 0 exactly one turnaround clock follows it before the strobe, and in sub-mode 1 the strobe follows it directly.
- R2: The read strobe `rd_n` stays low for 2*(code+1) - trim consecutive clocks, where code is the effective 2-bit wait-state code (0..3) and trim is the effective trim bit. Widths 1 through 8 are therefore possible.
- R3: When `cfg_percs_en` is 1, the sub-mode, code and trim of select i come from `cs_mode[2i+1:2i]`, `cs_ws[2i+1:2i]` and `cs_trim[i]`. When `cfg_percs_en` is 0, they come from `glob_mode`, `glob_ws` and `glob_trim` for every select.
- R4: In sub-mode 0 (multiplexed), `ale` and `ad_oe` are 1 with `ad_out` equal to the address bits [7:0] during the address phase. `ad_oe` is 0 during the turnaround and the strobe.
- R5: In sub-mode 1 (separate buses), `addr_out` carries the full request address for the whole access, and `ale` and `ad_oe` stay 0.
- R6: `rdata` equals the value on `ad_in` at the clock edge where `rd_n` returns high. `done` is 1 for exactly the one clock after that edge.
- R7: From the clock after acceptance until `done`, exactly the bit `cs_n[req_cs]` is 0. All `cs_n` bits are 1 in the `done` clock and while idle.
- R8: A request whose effective sub-mode is 2 or 3 is dropped: `idle` stays 1, `cs_n` stays all ones and `done` stays 0.
- R9: A request presented while `idle` is 0 is ignored. Configuration changes after acceptance do not alter the access in progress.
- R10: After a synchronous active-low reset, `idle`=1, `rd_n`=1, `cs_n` all ones, and `ale`, `ad_oe` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request, taken while idle |
| req_addr | input | ADDR_W | Read address |
| req_cs | input | CS_W | Chip-select index |
| cfg_percs_en | input | 1 | 1 selects the per-select settings |
| cs_mode | input | 2*NUM_CS | Per-select sub-mode codes |
| cs_ws | input | 2*NUM_CS | Per-select wait-state codes |
| cs_trim | input | NUM_CS | Per-select one-clock trim bits |
| glob_mode | input | 2 | Global sub-mode code |
| glob_ws | input | 2 | Global wait-state code |
| glob_trim | input | 1 | Global trim bit |
| ad_in | input | 8 | Data bus input |
| ad_out | output | 8 | AD bus output (address in sub-mode 0) |
| ad_oe | output | 1 | AD bus output enable |
| addr_out | output | ADDR_W | Separate address bus (sub-mode 1) |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| cs_n | output | NUM_CS | Active-low chip selects |
| idle | output | 1 | Block can take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read byte |

## Verification
The bench sweeps both selects, both enable settings, every wait-state code, both trim values and both valid sub-modes. The per-select and global fields are set to different values, so a selection mux that takes the wrong source shows up as the wrong width or the wrong bus mode. The data lines change on every strobe clock, so a capture one edge early or late returns a neighbouring byte, and a width off by one or a trim ignored at code 0 shows up in the strobe count. Other tests issue reserved sub-modes, hold a request high through an access and change the configuration in mid-cycle. A design that started a reserved access, launched a second cycle or re-read live configuration would produce extra chip-select activity or a wrong strobe width.

// File: rtl/hbrd_pkg.sv
// Shared types for the host bus read strobe timer.
package hbrd_pkg;
    // Bus sub-mode codes as seen on the configuration inputs.
    typedef enum logic [1:0] {
        MODE_MUX    = 2'd0,
        MODE_SPLIT  = 2'd1,
        MODE_RSVD2  = 2'd2,
        MODE_RSVD3  = 2'd3
    } bus_mode_e;

    // Access sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_TURN,
        ST_STRB,
        ST_DONE
    } acc_state_e;
endpackage

// File: rtl/hbrd_cfg_sel.sv
// Picks the effective sub-mode and strobe width for one request.
// Assumes: per-select fields are packed with select i at [2i+1:2i]
// (trim at bit i). Purely combinational.
module hbrd_cfg_sel
    import hbrd_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    parameter int CNT_W  = 4
) (
    input  logic [CS_W-1:0]     sel_cs,
    input  logic                percs_en,
    input  logic [2*NUM_CS-1:0] cs_mode,
    input  logic [2*NUM_CS-1:0] cs_ws,
    input  logic [NUM_CS-1:0]   cs_trim,
    input  logic [1:0]          glob_mode,
    input  logic [1:0]          glob_ws,
    input  logic                glob_trim,
    output bus_mode_e           eff_mode,
    output logic [CNT_W-1:0]    eff_width,
    output logic                eff_rsvd
);
    logic [1:0] mode_raw;
    logic [1:0] ws_raw;
    logic       trim_raw;

    // Source select: per-select fields only when enabled.
    always_comb begin
        mode_raw = glob_mode;
        ws_raw   = glob_ws;
        trim_raw = glob_trim;
        if (percs_en) begin
            mode_raw = cs_mode[2*sel_cs +: 2];
            ws_raw   = cs_ws[2*sel_cs +: 2];
            trim_raw = cs_trim[sel_cs];
        end
    end

    // Width = 2 clocks per code step, minus optional trim.
    always_comb begin
        eff_mode  = bus_mode_e'(mode_raw);
        eff_rsvd  = mode_raw[1];
        eff_width = CNT_W'({ws_raw, 1'b0}) + CNT_W'(2) - CNT_W'(trim_raw);
    end
endmodule

// File: rtl/hbrd_phase_timer.sv
// Down-counter timing one bus phase. Loading N-1 makes `expired`
// first true N clocks later. Assumes load value fits CNT_W.
module hbrd_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Count down to zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/hbrd_read_ctrl.sv
// Host bus read cycle generator: address phase, optional bus turnaround
// (multiplexed mode), timed read strobe, data capture and done pulse.
// Assumes: one access at a time, ADDR_CYC >= 1, 8-bit data bus.
module hbrd_read_ctrl
    import hbrd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_CS   = 2,
    parameter int ADDR_CYC = 2,
    parameter int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [CS_W-1:0]     req_cs,
    input  logic                cfg_percs_en,
    input  logic [2*NUM_CS-1:0] cs_mode,
    input  logic [2*NUM_CS-1:0] cs_ws,
    input  logic [NUM_CS-1:0]   cs_trim,
    input  logic [1:0]          glob_mode,
    input  logic [1:0]          glob_ws,
    input  logic                glob_trim,
    input  logic [7:0]          ad_in,
    output logic [7:0]          ad_out,
    output logic                ad_oe,
    output logic [ADDR_W-1:0]   addr_out,
    output logic                ale,
    output logic                rd_n,
    output logic [NUM_CS-1:0]   cs_n,
    output logic                idle,
    output logic                done,
    output logic [7:0]          rdata
);
    localparam int MAX_PH = (ADDR_CYC > 8) ? ADDR_CYC : 8;
    localparam int CNT_W  = $clog2(MAX_PH + 1);

    acc_state_e        state_q, state_d;
    bus_mode_e         sel_mode;
    logic [CNT_W-1:0]  sel_width;
    logic              sel_rsvd;
    logic              mux_q;
    logic [CNT_W-1:0]  width_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CS_W-1:0]   cs_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic              accept;

    hbrd_cfg_sel #(.NUM_CS(NUM_CS), .CS_W(CS_W), .CNT_W(CNT_W)) u_cfg (
        .sel_cs    (req_cs),
        .percs_en  (cfg_percs_en),
        .cs_mode   (cs_mode),
        .cs_ws     (cs_ws),
        .cs_trim   (cs_trim),
        .glob_mode (glob_mode),
        .glob_ws   (glob_ws),
        .glob_trim (glob_trim),
        .eff_mode  (sel_mode),
        .eff_width (sel_width),
        .eff_rsvd  (sel_rsvd)
    );

    hbrd_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    assign accept = (state_q == ST_IDLE) && req_valid && !sel_rsvd;

    // Next-state and timer load decode.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                state_d  = ST_ADDR;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(ADDR_CYC - 1);
            end
            ST_ADDR: if (tmr_exp) begin
                if (mux_q) begin
                    state_d = ST_TURN;
                end else begin
                    state_d  = ST_STRB;
                    tmr_load = 1'b1;
                    tmr_val  = width_q - 1'b1;
                end
            end
            ST_TURN: begin
                state_d  = ST_STRB;
                tmr_load = 1'b1;
                tmr_val  = width_q - 1'b1;
            end
            ST_STRB: if (tmr_exp) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch request and effective configuration at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_q   <= 1'b0;
            width_q <= CNT_W'(2);
            addr_q  <= '0;
            cs_q    <= '0;
        end else if (accept) begin
            mux_q   <= (sel_mode == MODE_MUX);
            width_q <= sel_width;
            addr_q  <= req_addr;
            cs_q    <= req_cs;
        end
    end

    // Capture read data on the edge that ends the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (state_q == ST_STRB && tmr_exp)
            rdata <= ad_in;
    end

    // Bus pin decode from the registered state.
    always_comb begin
        logic active;
        active   = (state_q == ST_ADDR) || (state_q == ST_TURN) || (state_q == ST_STRB);
        ale      = (state_q == ST_ADDR) && mux_q;
        ad_oe    = ale;
        ad_out   = ale ? addr_q[7:0] : 8'h00;
        addr_out = (active && !mux_q) ? addr_q : '0;
        rd_n     = (state_q != ST_STRB);
        idle     = (state_q == ST_IDLE);
        done     = (state_q == ST_DONE);
        for (int i = 0; i < NUM_CS; i++)
            cs_n[i] = !(active && (cs_q == CS_W'(i)));
    end

    // R7
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);
    // R4
    ad_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> done);
    // R7
    strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (cs_n != '1));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (rd_n && !ale && !ad_oe && (cs_n == '1)));
endmodule

// File: tb/hbrd_read_ctrl_tb.sv
module hbrd_read_ctrl_tb;
    localparam int ADDR_W   = 16;
    localparam int NUM_CS   = 2;
    localparam int ADDR_CYC = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [0:0]        req_cs = '0;
    logic              cfg_percs_en = 1'b0;
    logic [3:0]        cs_mode = '0;
    logic [3:0]        cs_ws = '0;
    logic [1:0]        cs_trim = '0;
    logic [1:0]        glob_mode = '0;
    logic [1:0]        glob_ws = '0;
    logic              glob_trim = 1'b0;
    logic [7:0]        ad_in = '0;
    logic [7:0]        ad_out;
    logic              ad_oe;
    logic [ADDR_W-1:0] addr_out;
    logic              ale;
    logic              rd_n;
    logic [1:0]        cs_n;
    logic              idle;
    logic              done;
    logic [7:0]        rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] pat = 8'h11;

    always #5 clk = ~clk;

    hbrd_read_ctrl #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .ADDR_CYC(ADDR_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_cs(req_cs), .cfg_percs_en(cfg_percs_en), .cs_mode(cs_mode),
        .cs_ws(cs_ws), .cs_trim(cs_trim), .glob_mode(glob_mode),
        .glob_ws(glob_ws), .glob_trim(glob_trim), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .addr_out(addr_out), .ale(ale),
        .rd_n(rd_n), .cs_n(cs_n), .idle(idle), .done(done), .rdata(rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // One access; hold>0 keeps the request high and scrambles config in mid-cycle (R9).
    task automatic run_txn(input int cs, input logic [ADDR_W-1:0] addr,
                           input bit exp_mux, input int exp_w, input int hold);
        int pre = 0, strb = 0, guard = 0;
        bit bad_ale = 0, bad_oe = 0, bad_ad = 0, bad_addr = 0, bad_cs = 0;
        logic [7:0] last = '0;
        logic [1:0] exp_cs;
        exp_cs = (cs == 0) ? 2'b10 : 2'b01;
        req_addr = addr; req_cs = cs[0]; req_valid = 1'b1;
        @(negedge clk);
        if (hold == 0) req_valid = 1'b0;
        else begin
            req_cs = ~req_cs; cs_ws = ~cs_ws; glob_ws = ~glob_ws;
            cs_trim = ~cs_trim; glob_trim = ~glob_trim;
        end
        while (rd_n && guard < 40) begin
            if (cs_n != exp_cs) bad_cs = 1;
            if (exp_mux && pre < ADDR_CYC && (!ale || !ad_oe || ad_out != addr[7:0])) bad_ad = 1;
            if (exp_mux && pre >= ADDR_CYC && ad_oe) bad_oe = 1;
            if (!exp_mux && (ale || ad_oe)) bad_ale = 1;
            if (!exp_mux && addr_out != addr) bad_addr = 1;
            pre++; guard++;
            if (pre >= hold) req_valid = 1'b0;
            @(negedge clk);
        end
        while (!rd_n && guard < 40) begin
            if (cs_n != exp_cs) bad_cs = 1;
            if (ad_oe || ale) bad_oe = 1;
            if (!exp_mux && addr_out != addr) bad_addr = 1;
            pat = pat + 8'd29; ad_in = pat; last = pat;
            strb++; guard++;
            req_valid = 1'b0;
            @(negedge clk);
        end
        // R1: address phase plus turnaround count
        check(pre == ADDR_CYC + (exp_mux ? 1 : 0), "R1 pre-strobe clocks", pre, ADDR_CYC + (exp_mux ? 1 : 0));
        // R2 / R3: strobe width from the effective source
        check(strb == exp_w, "R2/R3 strobe width", strb, exp_w);
        check(!bad_ad && !bad_oe, "R4 mux address drive/release", int'(bad_ad), 0);
        check(!bad_ale && !bad_addr, "R5 split address bus", int'(bad_addr), 0);
        check(!bad_cs, "R7 chip select held", int'(bad_cs), 0);
        check(done && rdata == last, "R6 capture at strobe end", int'(rdata), int'(last));
        check(cs_n == 2'b11, "R7 cs released at done", int'(cs_n), 3);
        @(negedge clk);
        check(!done && idle, "R6 done single pulse", int'(done), 0);
        // R9: no second access from a held request
        for (int k = 0; k < 3; k++) begin
            check(cs_n == 2'b11 && idle, "R9 no extra access", int'(cs_n), 3);
            @(negedge clk);
        end
    endtask

    initial begin
        for (int c = 0; c < 2000; c++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual 0 expected 1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(idle && rd_n && cs_n == 2'b11 && !ale && !ad_oe && !done,
              "R10 reset outputs", int'({idle, rd_n, cs_n, ale, ad_oe, done}), 7'b1111000);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep select, source, code, trim and sub-mode (R1-R7).
        for (int cs = 0; cs < 2; cs++)
          for (int en = 0; en < 2; en++)
            for (int w = 0; w < 4; w++)
              for (int t = 0; t < 2; t++)
                for (int m = 0; m < 2; m++) begin
                    int ew, em;
                    cfg_percs_en = en[0];
                    cs_ws   = {2'(3 - w), 2'(w)};
                    cs_trim = {~t[0], t[0]};
                    cs_mode = {~m[0] ? 2'd1 : 2'd0, 2'(m)};
                    glob_ws   = 2'((w + 1) % 4);
                    glob_trim = ~t[0];
                    glob_mode = {1'b0, ~m[0]};
                    if (en == 1) begin
                        int cw; int ct;
                        cw = (cs == 0) ? w : 3 - w;
                        ct = (cs == 0) ? t : 1 - t;
                        ew = 2 * (cw + 1) - ct;
                        em = (cs == 0) ? m : 1 - m;
                    end else begin
                        ew = 2 * (((w + 1) % 4) + 1) - (1 - t);
                        em = 1 - m;
                    end
                    run_txn(cs, 16'hA500 + 16'(cs * 64 + en * 32 + w * 8 + t * 2 + m),
                            em == 0, ew, 0);
                end

        // R9: request held high and config scrambled during the access.
        cfg_percs_en = 1'b1; cs_mode = 4'b0000; cs_ws = 4'b0010; cs_trim = 2'b01;
        glob_mode = 2'd1;
        run_txn(0, 16'h1234, 1'b1, 5, 3);

        // R8: reserved sub-modes, per-select and global.
        for (int r = 2; r < 4; r++)
            for (int en = 0; en < 2; en++) begin
                bit moved = 0;
                cfg_percs_en = en[0];
                cs_mode = {2'(r), 2'(r)};
                glob_mode = 2'(r);
                req_cs = 1'b1; req_valid = 1'b1;
                for (int k = 0; k < 6; k++) begin
                    @(negedge clk);
                    if (!idle || cs_n != 2'b11 || done || !rd_n) moved = 1;
                end
                req_valid = 1'b0;
                check(!moved, "R8 reserved mode dropped", int'(moved), 0);
            end
        finish_run();
    end
endmodule